// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block decides which of three operating modes a CAN controller is in: normal, initialization or sleep. Software asks for a mode through two request bits in a control register. The block answers with two acknowledge bits that show the mode actually in force. It also keeps three latched event flags: sleep entered, wakeup seen and error seen. Each flag combines with its own enable bit to drive one status-change interrupt line.

Requests to enter a mode take effect at once. Leaving initialization or sleep for normal operation is a different case. The block waits until the bus has been idle for a whole run of recessive bits, so that the controller joins the bus between frames. The receive line arrives already sampled, one sample per bit, marked by a one-cycle bit strobe. Error detection lives outside this block and reports each error as a single-cycle pulse.

The register port is a single address bus with a write enable. Reads are combinational, so read data follows the address in the same cycle.

Top module: `can_mode_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, the block is in sleep mode. Register 0 reads 0x02 (sleep request set), register 1 reads 0x00 and register 2 reads 0x02 (sleep acknowledge only), and `irq` is low.
- R2: Register 0 bit 0 is the init request and bit 1 is the sleep request. When the init request is set, register 2 bit 0 (init acknowledge) reads 1 on the clock edge after the edge that stored the request, from any mode. This holds even when the sleep request is also set. Register 2 bit 1 then reads 0.
- R3: From normal mode, a stored sleep request with the init request clear sets register 2 bit 1 (sleep acknowledge) on the following edge.
- R4: Once both request bits are clear, initialization or sleep is left only after `IDLE_BITS` (11) strobed recessive samples (`bit_stb`=1, `rx_bit`=1) with no strobed dominant sample between them. A strobed dominant sample restarts the run, and cycles without a strobe do not count. The acknowledge bit clears one edge after the edge that took the last sample of the run.
- R5: Moving between initialization and sleep needs no idle run. Clearing the init request while the sleep request is set puts the block in sleep on the next edge.
- R6: Register 2 bit 3 (wakeup flag) sets when a strobed dominant sample arrives while in sleep mode. Only a software clear resets it.
- R7: Register 2 bit 4 (sleep flag) sets on entry to sleep only if register 1 bit 1 is 1 at that moment. It clears on the same edge on which the sleep acknowledge clears.
- R8: Register 2 bit 2 (error flag) sets on an `err_evt` pulse only when register 1 bit 2 is 1.
- R9: Writing register 2 clears each flag in bits 4..2 whose written bit is 1. A written 0 leaves the flag as it is. A hardware set in the same cycle wins over the clear.
- R10: `irq` is high exactly when at least one flag is set together with its enable bit. The enable bits in register 1 are bit 0 for wakeup, bit 1 for sleep and bit 2 for error.
- R11: Register 0 and register 1 read back the last value written to their defined bits. All other bits, and address 3, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid receive sample |
| rx_bit | input | 1 | Sampled receive line, 1 = recessive, 0 = dominant |
| err_evt | input | 1 | One-cycle error detection pulse |
| wr_en | input | 1 | Register write enable |
| addr | input | 2 | Register address for read and write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| irq | output | 1 | Status-change interrupt |

## Verification
The assertions take two things for granted about the inputs. First, `bit_stb`, `rx_bit` and `err_evt` are stable across each sampling edge. Second, reset is held for at least two edges, so that the counter and mode registers hold known values before any past-value check looks back. The bench drives every input a short delay after the falling edge, and it holds reset for three edges. Strobes come as isolated one-cycle pulses with recessive idle cycles between them. This checks that cycles with no strobe do not add to the idle run.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_INIT   = 2'd1,
        MODE_SLEEP  = 2'd2
    } mode_t;

    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_IEN  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 2'd2;

    // control register bits
    localparam int CTRL_INIT  = 0;
    localparam int CTRL_SLEEP = 1;

    // interrupt enable register bits
    localparam int IEN_WAKE  = 0;
    localparam int IEN_SLACK = 1;
    localparam int IEN_ERR   = 2;

    // status register bits
    localparam int STAT_INIT_ACK  = 0;
    localparam int STAT_SLEEP_ACK = 1;
    localparam int STAT_ERR       = 2;
    localparam int STAT_WAKE      = 3;
    localparam int STAT_SLACK     = 4;
    localparam int STAT_TOP       = STAT_SLACK;

    // latched flags, packed to match status bits 4..2
    typedef struct packed {
        logic slack;
        logic wake;
        logic err;
    } flags_t;

    // enables, packed to match register 1 bits 2..0
    typedef struct packed {
        logic err;
        logic slack;
        logic wake;
    } ien_t;

    function automatic flags_t ien_as_mask(ien_t e);
        flags_t m;
        m.slack = e.slack;
        m.wake  = e.wake;
        m.err   = e.err;
        return m;
    endfunction

endpackage

// File: rtl/can_mode_idle_cnt.sv
module can_mode_idle_cnt
    import can_mode_pkg::*;
#(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic bit_stb,
    input  logic rx_bit,
    output logic idle
);
    localparam int CNT_W = $clog2(IDLE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_BITS);

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            run_q <= '0;
        end else if (bit_stb) begin
            if (!rx_bit) begin
                run_q <= '0;
            end else if (run_q != CNT_MAX) begin
                run_q <= run_q + CNT_W'(1);
            end
        end
    end

    assign idle = (run_q == CNT_MAX);

    AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst)
        run_q <= CNT_MAX); // R4

    AST_DOMINANT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (arm && bit_stb && !rx_bit) |=> (run_q == '0)); // R4

    AST_NO_STROBE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (arm && !bit_stb) |=> $stable(run_q)); // R4

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  init_req,
    input  logic  sleep_req,
    input  logic  idle,
    output mode_t mode_q,
    output mode_t mode_d,
    output logic  arm
);
    always_comb begin
        mode_d = mode_q;
        if (init_req) begin
            mode_d = MODE_INIT;
        end else if (sleep_req) begin
            mode_d = MODE_SLEEP;
        end else if (mode_q != MODE_NORMAL && idle) begin
            mode_d = MODE_NORMAL;
        end
    end

    assign arm = (mode_q != MODE_NORMAL) && !init_req && !sleep_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_SLEEP;
        end else begin
            mode_q <= mode_d;
        end
    end

    AST_INIT_WINS: assert property (@(posedge clk) disable iff (rst)
        init_req |=> (mode_q == MODE_INIT)); // R2

    AST_SLEEP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!init_req && sleep_req) |=> (mode_q == MODE_SLEEP)); // R5

    AST_EXIT_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NORMAL && $past(mode_q) != MODE_NORMAL) |-> $past(idle)); // R4

endmodule

// File: rtl/can_mode_flags.sv
module can_mode_flags
    import can_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  mode_t  mode_q,
    input  mode_t  mode_d,
    input  logic   bit_stb,
    input  logic   rx_bit,
    input  logic   err_evt,
    input  ien_t   ien,
    input  flags_t w1c,
    output flags_t flags,
    output logic   irq
);
    logic enter_sleep;
    logic leave_sleep;
    logic wake_hit;

    assign enter_sleep = (mode_d == MODE_SLEEP) && (mode_q != MODE_SLEEP);
    assign leave_sleep = (mode_q == MODE_SLEEP) && (mode_d != MODE_SLEEP);
    assign wake_hit    = (mode_q == MODE_SLEEP) && bit_stb && !rx_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (wake_hit) begin
                flags.wake <= 1'b1;
            end else if (w1c.wake) begin
                flags.wake <= 1'b0;
            end

            if (err_evt && ien.err) begin
                flags.err <= 1'b1;
            end else if (w1c.err) begin
                flags.err <= 1'b0;
            end

            if (enter_sleep && ien.slack) begin
                flags.slack <= 1'b1;
            end else if (leave_sleep || w1c.slack) begin
                flags.slack <= 1'b0;
            end
        end
    end

    assign irq = |(flags & ien_as_mask(ien));

    AST_WAKE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        wake_hit |=> flags.wake); // R6

    AST_SLACK_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (rst)
        leave_sleep |=> !flags.slack); // R7

    AST_SLACK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.slack) |-> $past(ien.slack)); // R7

    AST_ERR_MASKED: assert property (@(posedge clk) disable iff (rst)
        (!ien.err && !flags.err) |=> !flags.err); // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (err_evt && ien.err && w1c.err) |=> flags.err); // R9

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int IDLE_BITS = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_stb,
    input  logic                  rx_bit,
    input  logic                  err_evt,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  irq
);
    localparam int FLAG_W = $bits(flags_t);
    localparam int IEN_W  = $bits(ien_t);

    logic   init_req_q;
    logic   sleep_req_q;
    ien_t   ien_q;
    flags_t flags;
    flags_t w1c;
    mode_t  mode_q;
    mode_t  mode_d;
    logic   arm;
    logic   idle;
    logic   unused_wr_bits;

    assign unused_wr_bits = ^wr_data[DATA_W-1:STAT_TOP+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            init_req_q  <= 1'b0;
            sleep_req_q <= 1'b1;
            ien_q       <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_CTRL) begin
                init_req_q  <= wr_data[CTRL_INIT];
                sleep_req_q <= wr_data[CTRL_SLEEP];
            end
            if (addr == ADDR_IEN) begin
                ien_q <= ien_t'(wr_data[IEN_W-1:0]);
            end
        end
    end

    assign w1c = (wr_en && addr == ADDR_STAT) ? flags_t'(wr_data[STAT_TOP:STAT_ERR]) : '0;

    can_mode_idle_cnt #(.IDLE_BITS(IDLE_BITS)) idle_i (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .bit_stb (bit_stb),
        .rx_bit  (rx_bit),
        .idle    (idle)
    );

    can_mode_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .init_req  (init_req_q),
        .sleep_req (sleep_req_q),
        .idle      (idle),
        .mode_q    (mode_q),
        .mode_d    (mode_d),
        .arm       (arm)
    );

    can_mode_flags flags_i (
        .clk     (clk),
        .rst     (rst),
        .mode_q  (mode_q),
        .mode_d  (mode_d),
        .bit_stb (bit_stb),
        .rx_bit  (rx_bit),
        .err_evt (err_evt),
        .ien     (ien_q),
        .w1c     (w1c),
        .flags   (flags),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_CTRL: begin
                rd_data[CTRL_INIT]  = init_req_q;
                rd_data[CTRL_SLEEP] = sleep_req_q;
            end
            ADDR_IEN: begin
                rd_data[IEN_W-1:0] = ien_q;
            end
            ADDR_STAT: begin
                rd_data[STAT_INIT_ACK]           = (mode_q == MODE_INIT);
                rd_data[STAT_SLEEP_ACK]          = (mode_q == MODE_SLEEP);
                rd_data[STAT_TOP -: FLAG_W]      = flags;
            end
            default: rd_data = '0;
        endcase
    end

    AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
        !((mode_q == MODE_INIT) && (mode_q == MODE_SLEEP)) && (mode_q != 2'd3)); // R2

    AST_WRITE_STICKS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_CTRL) |=> (init_req_q == $past(wr_data[CTRL_INIT]))); // R11

endmodule

// File: tb/can_mode_ctrl_tb.sv
module can_mode_ctrl_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          bit_stb;
    logic          rx_bit;
    logic          err_evt;
    logic          wr_en;
    logic [1:0]    addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // behavioural reference state
    int   m_mode;      // 0 normal, 1 init, 2 sleep
    int   m_run;
    bit   m_ireq, m_sreq;
    bit [2:0] m_ie;    // [0] wake, [1] sleep, [2] error
    bit   m_wake, m_err, m_slack;

    always #5 clk = ~clk;

    can_mode_ctrl #(.DATA_W(DW), .IDLE_BITS(11)) dut_i (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .rx_bit(rx_bit),
        .err_evt(err_evt), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // reference model update
    always @(posedge clk) begin
        int nm;
        bit pend;
        bit [DW-1:0] clr;
        cyc++;
        if (rst) begin
            m_mode = 2; m_run = 0; m_ireq = 0; m_sreq = 1; m_ie = 0;
            m_wake = 0; m_err = 0; m_slack = 0;
        end else begin
            pend = (m_mode != 0) && !m_ireq && !m_sreq;
            if (m_ireq) nm = 1;
            else if (m_sreq) nm = 2;
            else if (m_mode != 0 && m_run == 11) nm = 0;
            else nm = m_mode;
            clr = (wr_en && addr == 2) ? wr_data : '0;
            if (m_mode == 2 && bit_stb && !rx_bit) m_wake = 1;
            else if (clr[3]) m_wake = 0;
            if (err_evt && m_ie[2]) m_err = 1;
            else if (clr[2]) m_err = 0;
            if (nm == 2 && m_mode != 2 && m_ie[1]) m_slack = 1;
            else if ((m_mode == 2 && nm != 2) || clr[4]) m_slack = 0;
            if (!pend) m_run = 0;
            else if (bit_stb) m_run = rx_bit ? ((m_run < 11) ? m_run + 1 : 11) : 0;
            if (wr_en && addr == 0) begin m_ireq = wr_data[0]; m_sreq = wr_data[1]; end
            if (wr_en && addr == 1) m_ie = wr_data[2:0];
            m_mode = nm;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            if (addr == 2) begin
                chk(rd_data[0], m_mode == 1, "R2 init ack");
                chk(rd_data[1], m_mode == 2, "R3 sleep ack");
                chk(rd_data[2], m_err, "R8 error flag");
                chk(rd_data[3], m_wake, "R6 wakeup flag");
                chk(rd_data[4], m_slack, "R7 sleep flag");
            end else if (addr == 0) begin
                chk(rd_data, {m_sreq, m_ireq}, "R11 ctrl read");
            end else if (addr == 1) begin
                chk(rd_data, m_ie, "R11 enable read");
            end
            chk(irq, (m_wake & m_ie[0]) | (m_slack & m_ie[1]) | (m_err & m_ie[2]), "R10 irq");
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            summary();
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1; addr = a; wr_data = d;
        tick();
        wr_en = 0; addr = 2; wr_data = '0;
    endtask

    task automatic bits(input int n, input logic v);
        for (int i = 0; i < n; i++) begin
            bit_stb = 1; rx_bit = v;
            tick();
            bit_stb = 0; rx_bit = 1;
            tick();
            tick();
        end
    endtask

    initial begin
        rst = 1; bit_stb = 0; rx_bit = 1; err_evt = 0;
        wr_en = 0; addr = 2; wr_data = '0;
        repeat (3) @(negedge clk);
        chk(rd_data, 8'h02, "R1 reset status");
        chk(irq, 0, "R1 reset irq");
        #2 rst = 0;
        tick();
        chk(rd_data, 8'h02, "R1 status after release");

        wr(1, 8'h07);
        wr(0, 8'h00);                 // leave sleep
        bits(5, 1);
        bits(1, 0);                   // dominant restarts run, also wakes
        chk(rd_data[3], 1, "R6 wakeup latched");
        bits(10, 1);
        chk(rd_data[1], 1, "R4 still asleep after 10 bits");
        bits(1, 1);
        chk(rd_data[1], 0, "R4 awake after 11 bits");
        chk(rd_data[3], 1, "R6 wakeup kept after exit");
        wr(2, 8'h00);
        chk(rd_data[3], 1, "R9 zero write keeps flag");
        chk(irq, 1, "R10 irq from wakeup");
        wr(2, 8'h08);
        chk(rd_data[3], 0, "R9 wakeup cleared");

        wr(0, 8'h02);
        tick();
        chk(rd_data[1], 1, "R3 sleep entered");
        chk(rd_data[4], 1, "R7 sleep flag set");
        wr(0, 8'h03);
        tick();
        chk(rd_data[1:0], 2'b01, "R2 init wins over sleep");
        chk(rd_data[4], 0, "R7 sleep flag dropped with ack");
        wr(0, 8'h02);
        tick();
        chk(rd_data[1:0], 2'b10, "R5 init to sleep directly");
        wr(0, 8'h00);
        bits(11, 1);
        chk(rd_data[1:0], 2'b00, "R4 normal after sleep exit");

        err_evt = 1; tick(); err_evt = 0;
        chk(rd_data[2], 1, "R8 error flag set");
        err_evt = 1; wr(2, 8'h04); err_evt = 0;
        chk(rd_data[2], 1, "R9 set beats clear");
        wr(2, 8'h04);
        chk(rd_data[2], 0, "R9 error cleared");
        wr(1, 8'h03);
        err_evt = 1; tick(); err_evt = 0;
        chk(rd_data[2], 0, "R8 masked error ignored");
        chk(irq, 0, "R10 irq idle");

        wr(1, 8'h00);
        wr(0, 8'h02);
        tick();
        chk(rd_data[4:1], 4'b0001, "R7 no flag when disabled");
        wr(0, 8'h01);
        tick();
        wr(0, 8'h00);
        bits(4, 1);
        chk(rd_data[0], 1, "R4 init held during run");
        bits(7, 1);
        chk(rd_data[0], 0, "R4 init left after run");

        wr(0, 8'h01);
        wr(1, 8'h05);
        addr = 0; #1;
        chk(rd_data, 8'h01, "R11 ctrl readback");
        addr = 1; #1;
        chk(rd_data, 8'h05, "R11 enable readback");
        addr = 3; #1;
        chk(rd_data, 8'h00, "R11 unused address");
        addr = 2;
        tick();
        tick();
        summary();
    end
endmodule